// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a processor reach the management registers of external PHY devices over a two-wire MDC/MDIO link. Software programs a small register file through a plain 32-bit register port. It loads the PHY and register number, loads the data word for a write, and then writes the command register with the start bit and an access code. The block then shifts out a complete Clause 22 management frame. For a read it releases the data line and captures the 16-bit answer from the PHY.

While a frame is in flight, a busy flag in the command register reads as 1. Software polls that flag and, once it clears, fetches the captured word from the read-data register. A clause-select bit in the mode register is stored and reads back, but the frame format is always Clause 22. The register port has no back-pressure: every access is taken in the cycle it is presented, and read data appears on the cycle after. MDC is the system clock divided by the even parameter `DIV`. The line changes after each MDC fall and is sampled on each MDC rise.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every mapped register reads 0, the busy flag is 0, `mdc` is low and `mdio_oe` is low.
- R2: Register map (byte offsets on `bus_addr`): 0x40 mode (all 32 bits stored), 0x44 address (PHY in [12:8], register in [4:0], other bits read 0), 0x48 write data ([15:0] stored, upper bits read 0), 0x4C read data ([15:0], read-only, writes ignored) and 0x50 command. An unmapped offset reads 0. Read data is on `bus_rdata` one cycle after the read request.
- R3: A write to 0x50 with bit 8 set while idle starts a frame. Bit 0 of that write is the access code (0 = read, 1 = write) and reads back in bit 0. Busy (bit 16) reads 1 from the cycle after the write.
- R4: Each frame is 64 MDC periods, sent MSB first, and each period is `DIV` clocks with MDC high for the second half. The frame starts with 32 ones, then start bits 01, then opcode 10 for read or 01 for write, then the 5-bit PHY address and the 5-bit register number. MDC stays low while idle.
- R5: In a write frame the master drives all 64 bits. The turnaround bits are 10, followed by write data [15:0].
- R6: In a read frame `mdio_oe` is low from bit 46 (turnaround) through bit 63. Bits 48..63 are sampled at MDC rise, and read data holds them once busy clears. A write frame leaves read data unchanged.
- R7: A start written while busy is ignored. The running frame continues, no second frame follows, and the stored access code is not changed.
- R8: Address and write-data writes made while busy do not alter the running frame. They are used by the next frame.
- R9: Mode bit 8 (0 = Clause 22, 1 = Clause 45) is stored with the rest of the mode word. Frames keep Clause 22 framing (start bits 01) whichever value it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
On every cycle the assertions check the following:
- busy rises after an accepted start;
- MDC only rises while busy, and MDC and the output enable stay low when idle;
- read data stays frozen for the length of a frame;
- a mode write is stored.

Frame content and turnaround ownership can only be shown by the bench's PHY model, which decodes each frame bit by bit. The same applies to the read value matching the PHY's memory, to the rejection of a start during busy, and to the isolation of a running frame from register writes.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned OFS_W     = 8;
  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned TA_IDX    = 46;
  localparam int unsigned DATA_IDX  = 48;

  localparam logic [OFS_W-1:0] OFS_MODE  = 8'h40;
  localparam logic [OFS_W-1:0] OFS_ADDR  = 8'h44;
  localparam logic [OFS_W-1:0] OFS_WDATA = 8'h48;
  localparam logic [OFS_W-1:0] OFS_RDATA = 8'h4C;
  localparam logic [OFS_W-1:0] OFS_CMD   = 8'h50;

  localparam int unsigned CMD_GO_BIT   = 8;
  localparam int unsigned CMD_BUSY_BIT = 16;

  // Clause 22 frame image, bit 63 goes out first.
  function automatic logic [FRAME_LEN-1:0] c22_frame(input logic is_wr,
                                                     input logic [4:0] phy,
                                                     input logic [4:0] ra,
                                                     input logic [15:0] wd);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dat;
    op  = is_wr ? 2'b01 : 2'b10;
    ta  = is_wr ? 2'b10 : 2'b11;
    dat = is_wr ? wd : 16'hFFFF;
    return {32'hFFFF_FFFF, 2'b01, op, phy, ra, ta, dat};
  endfunction
endpackage

// File: rtl/mdc_timer.sv
module mdc_timer #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_ev = run && (cnt == CW'(HALF - 1));
  assign fall_ev = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_ev ? '0 : cnt + CW'(1);
      if (rise_ev) mdc <= 1'b1;
      if (fall_ev) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_ev_i,
  input  logic        fall_ev_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [15:0] rdata_o
);
  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     idx;
  logic                 wr_q;
  logic [15:0]          cap;

  assign mdio_o    = shreg[FRAME_LEN-1];
  assign mdio_oe_o = busy_o && (wr_q || (idx < IDX_W'(TA_IDX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      wr_q    <= 1'b0;
      cap     <= '0;
      rdata_o <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        shreg  <= c22_frame(wr_i, phy_i, reg_i, wdata_i);
        idx    <= '0;
        wr_q   <= wr_i;
      end
    end else begin
      if (rise_ev_i && !wr_q && (idx >= IDX_W'(DATA_IDX)))
        cap <= {cap[14:0], mdio_i};
      if (fall_ev_i) begin
        shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
        idx   <= idx + IDX_W'(1);
        if (idx == IDX_W'(FRAME_LEN - 1)) begin
          busy_o <= 1'b0;
          if (!wr_q) rdata_o <= cap;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             busy_i,
  input  logic [15:0]      rdata_i,
  output logic             start_o,
  output logic             wr_o,
  output logic [4:0]       phy_o,
  output logic [4:0]       reg_o,
  output logic [15:0]      wdata_o,
  output logic [REG_W-1:0] mode_o
);
  logic             code_q;
  logic             wr_hit;
  logic [REG_W-1:0] rd_mux;

  assign wr_hit  = bus_sel && bus_wr;
  assign start_o = wr_hit && (bus_addr == OFS_CMD) && bus_wdata[CMD_GO_BIT] && !busy_i;
  assign wr_o    = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o  <= '0;
      phy_o   <= '0;
      reg_o   <= '0;
      wdata_o <= '0;
      code_q  <= 1'b0;
    end else if (wr_hit) begin
      case (bus_addr)
        OFS_MODE:  mode_o <= bus_wdata;
        OFS_ADDR: begin
          phy_o <= bus_wdata[12:8];
          reg_o <= bus_wdata[4:0];
        end
        OFS_WDATA: wdata_o <= bus_wdata[15:0];
        OFS_CMD:   if (!busy_i) code_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_MODE:  rd_mux = mode_o;
      OFS_ADDR:  rd_mux = {19'd0, phy_o, 3'd0, reg_o};
      OFS_WDATA: rd_mux = {16'd0, wdata_o};
      OFS_RDATA: rd_mux = {16'd0, rdata_i};
      OFS_CMD: begin
        rd_mux[CMD_BUSY_BIT] = busy_i;
        rd_mux[0]            = code_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        eng_busy;
  logic [15:0] eng_rdata;
  logic        go;
  logic        go_wr;
  logic [4:0]  csr_phy;
  logic [4:0]  csr_reg;
  logic [15:0] csr_wdata;
  logic [31:0] csr_mode;
  logic        rise_ev;
  logic        fall_ev;

  mdio_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(eng_busy), .rdata_i(eng_rdata),
    .start_o(go), .wr_o(go_wr), .phy_o(csr_phy), .reg_o(csr_reg),
    .wdata_o(csr_wdata), .mode_o(csr_mode)
  );

  mdc_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .start_i(go), .wr_i(go_wr), .phy_i(csr_phy), .reg_i(csr_reg),
    .wdata_i(csr_wdata), .rise_ev_i(rise_ev), .fall_ev_i(fall_ev),
    .mdio_i(mdio_i), .busy_o(eng_busy), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .rdata_o(eng_rdata)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [15:0] rhold,
  input logic [31:0] mode_q
);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_GO_BIT] && !busy) |=> busy);

  // R4
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R4
  mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R6
  rdata_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rhold));

  // R9
  mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_MODE) |=> (mode_q == $past(bus_wdata)));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(eng_busy),
  .mdc(mdc), .mdio_oe(mdio_oe), .rhold(eng_rdata), .mode_q(csr_mode)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WD = 8'h48,
                         A_RD = 8'h4C, A_CMD = 8'h50;
  // {write, phy, reg, data}
  localparam logic [26:0] VEC [7] = '{
    {1'b1, 5'd1,  5'd3,  16'h1234},
    {1'b0, 5'd1,  5'd3,  16'h0000},
    {1'b0, 5'd31, 5'd0,  16'h0000},
    {1'b1, 5'd31, 5'd31, 16'hFFFF},
    {1'b0, 5'd0,  5'd31, 16'h0000},
    {1'b1, 5'd16, 5'd10, 16'h8001},
    {1'b0, 5'd16, 5'd10, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire mdc, mo, moe;
  logic phy_drive = 1'b1;
  wire line = moe ? mo : phy_drive;

  mdio_mgmt_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .mdc(mdc), .mdio_o(mo),
    .mdio_oe(moe), .mdio_i(line)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit reported = 0;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] seed(input int i);
    return 16'hA500 ^ 16'(i * 16'h0137);
  endfunction

  // PHY model
  logic fb [64];
  logic oeb [64];
  int n = 0, frames = 0;
  logic [15:0] pmem [32];
  logic [15:0] gold [32];
  logic pre_ok, oe_ok;
  logic [1:0] l_st, l_op, l_ta;
  logic [4:0] l_phy, l_reg;
  logic [15:0] l_dat;

  always @(posedge mdc) begin
    fb[n] = line;
    oeb[n] = moe;
    n++;
    if (n == 64) begin
      pre_ok = 1'b1;
      for (int i = 0; i < 32; i++) if (fb[i] !== 1'b1) pre_ok = 1'b0;
      l_st = {fb[32], fb[33]};
      l_op = {fb[34], fb[35]};
      for (int i = 0; i < 5; i++) begin
        l_phy[4-i] = fb[36+i];
        l_reg[4-i] = fb[41+i];
      end
      l_ta = {fb[46], fb[47]};
      for (int i = 0; i < 16; i++) l_dat[15-i] = fb[48+i];
      oe_ok = 1'b1;
      for (int i = 0; i < 64; i++)
        if (oeb[i] !== ((l_op == 2'b01) || (i < 46))) oe_ok = 1'b0;
      if (l_op == 2'b01) pmem[l_reg] = l_dat;
      frames++;
      n = 0;
    end
  end

  always @(negedge mdc) begin
    if (n >= 46 && fb[34] === 1'b1 && fb[35] === 1'b0) begin
      if (n == 46)      phy_drive = 1'b1;
      else if (n == 47) phy_drive = 1'b0;
      else              phy_drive = pmem[{fb[41], fb[42], fb[43], fb[44], fb[45]}][63-n];
    end else begin
      phy_drive = 1'b1;
    end
  end

  // MDC high-phase width monitor
  int hi_cnt = 0, phase_err = 0;
  always @(negedge clk) begin
    if (mdc) hi_cnt++;
    else if (hi_cnt != 0) begin
      if (hi_cnt != HALF) phase_err++;
      hi_cnt = 0;
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic poll_idle();
    logic [31:0] v;
    int k = 0;
    do begin
      bus_read(A_CMD, v);
      k++;
    end while (v[16] && k < 4000);
  endtask

  task automatic check_frame(input string tag, input logic w, input logic [4:0] p,
                             input logic [4:0] r, input int f0);
    chk({tag, " R4 frame count"}, frames, f0 + 1);
    chk({tag, " R4 preamble"}, pre_ok, 1'b1);
    chk({tag, " R4 start bits"}, l_st, 2'b01);
    chk({tag, " R4 opcode"}, l_op, w ? 2'b01 : 2'b10);
    chk({tag, " R4 phy"}, l_phy, p);
    chk({tag, " R4 reg"}, l_reg, r);
    chk({tag, " R6 output enable pattern"}, oe_ok, 1'b1);
  endtask

  logic [31:0] v, prev_rd;
  int f0;

  initial begin
    for (int i = 0; i < 32; i++) begin
      pmem[i] = seed(i);
      gold[i] = seed(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 mdc", mdc, 0);
    chk("R1 oe", moe, 0);
    bus_read(A_MODE, v);  chk("R1 mode", v, 0);
    bus_read(A_ADDR, v);  chk("R1 addr", v, 0);
    bus_read(A_WD, v);    chk("R1 wdata", v, 0);
    bus_read(A_RD, v);    chk("R1 rdata", v, 0);
    bus_read(A_CMD, v);   chk("R1 cmd busy", v, 0);
    // R2 map and masks
    bus_write(A_MODE, 32'hDEAD_BEEF); bus_read(A_MODE, v); chk("R2 mode readback", v, 32'hDEAD_BEEF);
    bus_write(A_ADDR, 32'hFFFF_FFFF); bus_read(A_ADDR, v); chk("R2 addr mask", v, 32'h0000_1F1F);
    bus_write(A_WD, 32'hFFFF_FFFF);   bus_read(A_WD, v);   chk("R2 wdata mask", v, 32'h0000_FFFF);
    bus_write(A_RD, 32'h1234_5678);   bus_read(A_RD, v);   chk("R2 rdata read-only", v, 0);
    bus_read(8'h54, v); chk("R2 unmapped", v, 0);
    // R9 clear clause bit, keep others
    bus_write(A_MODE, 32'hDEAD_BEEF & ~32'h100); bus_read(A_MODE, v);
    chk("R9 mode clear keeps other bits", v, 32'hDEAD_BEEF & ~32'h100);
    prev_rd = 0;

    // Vector table
    for (int t = 0; t < 7; t++) begin
      logic w;
      logic [4:0] p, r;
      logic [15:0] d;
      {w, p, r, d} = VEC[t];
      f0 = frames;
      phase_err = 0;
      bus_write(A_ADDR, {19'd0, p, 3'd0, r});
      if (w) bus_write(A_WD, {16'd0, d});
      bus_write(A_CMD, 32'h100 | 32'(w));
      bus_read(A_CMD, v);
      chk($sformatf("R3 vec%0d busy after start", t), v[16], 1'b1);
      chk($sformatf("R3 vec%0d code readback", t), v[0], w);
      poll_idle();
      check_frame($sformatf("vec%0d", t), w, p, r, f0);
      chk($sformatf("R4 vec%0d mdc high phase", t), phase_err, 0);
      bus_read(A_RD, v);
      if (w) begin
        gold[r] = d;
        chk($sformatf("R5 vec%0d turnaround", t), l_ta, 2'b10);
        chk($sformatf("R5 vec%0d write data", t), l_dat, d);
        chk($sformatf("R6 vec%0d rdata kept on write", t), v, prev_rd);
      end else begin
        chk($sformatf("R6 vec%0d read data", t), v, {16'd0, gold[r]});
        prev_rd = v;
      end
    end

    // R7 start while busy ignored
    f0 = frames;
    bus_write(A_ADDR, 32'h0000_0207);
    bus_write(A_WD, 32'h0000_5A5A);
    bus_write(A_CMD, 32'h101);
    repeat (40) @(negedge clk);
    bus_write(A_CMD, 32'h100);
    bus_read(A_CMD, v);
    chk("R7 busy still set", v[16], 1'b1);
    chk("R7 code unchanged", v[0], 1'b1);
    poll_idle();
    chk("R7 single write frame op", l_op, 2'b01);
    chk("R7 write data intact", l_dat, 16'h5A5A);
    repeat (300) @(negedge clk);
    chk("R7 no extra frame", frames, f0 + 1);
    chk("R7 mdc idle", mdc, 0);

    // R8 register writes during busy
    f0 = frames;
    bus_write(A_ADDR, 32'h0000_0305);
    bus_write(A_CMD, 32'h100);
    repeat (20) @(negedge clk);
    bus_write(A_ADDR, 32'h0000_1109);
    bus_write(A_WD, 32'h0000_C3C3);
    poll_idle();
    chk("R8 running frame phy", l_phy, 5'd3);
    chk("R8 running frame reg", l_reg, 5'd5);
    bus_read(A_RD, v);
    chk("R8 read data", v, {16'd0, pmem[5]});
    bus_write(A_CMD, 32'h101);
    poll_idle();
    chk("R8 next frame phy", l_phy, 5'd17);
    chk("R8 next frame reg", l_reg, 5'd9);
    chk("R8 next frame data", l_dat, 16'hC3C3);
    chk("R8 frame count", frames, f0 + 2);

    // R9 clause 45 bit stored, framing stays Clause 22
    bus_write(A_MODE, 32'h0000_0100);
    bus_read(A_MODE, v);
    chk("R9 mode bit set", v, 32'h100);
    bus_write(A_ADDR, 32'h0000_0409);
    bus_write(A_CMD, 32'h100);
    poll_idle();
    chk("R9 start bits", l_st, 2'b01);
    chk("R9 opcode", l_op, 2'b10);
    bus_read(A_RD, v);
    chk("R9 read data", v, 32'h0000_C3C3);

    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end
endmodule